// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Cache Lookup

This block is the read lookup path of a direct-mapped first-level cache. The set is selected with address bits that lie inside the 8 KB page offset. Those bits are the same in the virtual and the physical address, so the tag and data arrays can be read in the cycle a request is accepted, while the translation of the virtual page is still in progress. The hit decision is taken later, when the translated physical page number arrives, by comparing it against the physical tag stored with the line.

Tags are never compared in the virtual domain. Two virtual addresses that translate to the same physical page therefore find the same line and both hit. A fault reported by translation overrides the comparison. A separate fill port writes a whole line, its physical tag and its valid bit after a miss. One lookup is in flight at a time.

Top module: `vipt_lookup`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1 and no response output is set, so the first lookup of any set reports a miss. This also holds after a reset applied in the middle of operation.
- R2: The set index is `req_vaddr[12:5]`, the word within the line is `req_vaddr[4:2]`, and bits 31:13 never affect the result. Two virtual addresses that share bits 12:0 and translate to the same physical page both hit on the same line.
- R3: A lookup hits when the selected line is valid and its stored tag equals `xlt_ppn`. `rsp_hit` then pulses, and `rsp_data` carries word `req_vaddr[4:2]` of the line.
- R4: A lookup whose line is invalid, or whose stored tag differs from `xlt_ppn`, pulses `rsp_miss`, and `rsp_data` is 0.
- R5: The translation inputs are sampled only while a lookup is pending. No response appears before the cycle after `xlt_valid` is seen in that state, for any number of waiting cycles. `xlt_valid` while idle has no effect.
- R6: If `xlt_fault` is 1 when translation completes, only `rsp_fault` pulses, whatever the tag comparison gives, and `rsp_data` is 0.
- R7: A fill with `fill_valid` writes `fill_ppn` as the tag of set `fill_set`, writes `fill_line` as its data (word w at bits `32*w+31 : 32*w`) and makes the line valid. A later lookup with a matching page then hits.
- R8: `req_ready` drops in the cycle after a request is accepted and returns with the response. A `req_valid` presented while `req_ready` is 0 is ignored and starts no lookup.
- R9: A lookup sees the line contents as they were at its acceptance edge. A fill in that same cycle, or while the lookup waits for translation, does not change its result, even for the same set.
- R10: Each accepted request produces exactly one of `rsp_hit`, `rsp_miss`, `rsp_fault`, as a pulse of one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vaddr | input | 32 | Virtual byte address of the request |
| req_ready | output | 1 | Block can accept a request |
| xlt_valid | input | 1 | Translation result is present |
| xlt_ppn | input | 19 | Translated physical page number |
| xlt_fault | input | 1 | Translation reported a fault |
| fill_valid | input | 1 | Write a line |
| fill_set | input | 8 | Set written by the fill |
| fill_ppn | input | 19 | Physical tag stored with the filled line |
| fill_line | input | 256 | Line data, word 0 in the low bits |
| rsp_hit | output | 1 | One-cycle hit indication |
| rsp_miss | output | 1 | One-cycle miss indication |
| rsp_fault | output | 1 | One-cycle fault indication |
| rsp_data | output | 32 | Selected word on a hit, otherwise 0 |

## Verification
A fill and a lookup can land in the same cycle, both at the acceptance edge and while the lookup waits for translation. The bench provokes both cases on a single set. In the first case it fills a line in the same cycle as a request to it and expects a miss, although the translated page equals the new tag. In the second case it replaces a line while a lookup of it is pending and expects a hit that returns the old word. Follow-up lookups then show that the fill did land.

// File: rtl/vipt_pkg.sv
package vipt_pkg;

   // Lookup controller: waiting for a request, or waiting for translation
   typedef enum logic {
      ST_IDLE = 1'b0,
      ST_LOOK = 1'b1
   } look_st_e;

   // Resolution of one access
   typedef enum logic [1:0] {
      RES_HIT   = 2'd0,
      RES_MISS  = 2'd1,
      RES_FAULT = 2'd2
   } res_e;

   function automatic res_e classify(input logic fault, input logic tag_match);
      if (fault)
         return RES_FAULT;
      else if (tag_match)
         return RES_HIT;
      else
         return RES_MISS;
   endfunction

endpackage

// File: rtl/vipt_tag_store.sv
module vipt_tag_store #(
   parameter int SETS  = 256,
   parameter int TAG_W = 19,
   localparam int IDX_W = $clog2(SETS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag
);

   logic [SETS-1:0]  line_vld;
   logic [TAG_W-1:0] tag_mem [SETS];

   // Valid bits are flops so that reset can clear them all at once
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         line_vld <= '0;
      else if (wr_en)
         line_vld[wr_idx] <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (wr_en)
         tag_mem[wr_idx] <= wr_tag;
   end

   // Registered read: returns the contents from before a write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_valid <= 1'b0;
      else if (rd_en)
         rd_valid <= line_vld[rd_idx];
   end

   always_ff @(posedge clk) begin
      if (rd_en)
         rd_tag <= tag_mem[rd_idx];
   end

   // R7: a fill leaves its set valid
   p_fill_sets_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> line_vld[$past(wr_idx)]);

   // R9: the captured valid bit does not move while no read is issued
   p_read_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_valid));

endmodule

// File: rtl/vipt_data_store.sv
module vipt_data_store #(
   parameter int SETS        = 256,
   parameter int WORDS       = 8,
   parameter int WORD_W      = 32,
   parameter bit LATE_SELECT = 1'b0,
   localparam int IDX_W  = $clog2(SETS),
   localparam int SEL_W  = $clog2(WORDS),
   localparam int LINE_W = WORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [SEL_W-1:0]  rd_sel,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [LINE_W-1:0] wr_line,
   output logic [WORD_W-1:0] rd_word
);

   logic [LINE_W-1:0] line_mem [SETS];

   always_ff @(posedge clk) begin
      if (wr_en)
         line_mem[wr_idx] <= wr_line;
   end

   generate
      if (LATE_SELECT) begin : g_late
         // Whole line registered, word chosen after the register
         logic [LINE_W-1:0] line_q;
         logic [SEL_W-1:0]  sel_q;
         logic [WORD_W-1:0] word_view [WORDS];

         always_ff @(posedge clk) begin
            if (rd_en) begin
               line_q <= line_mem[rd_idx];
               sel_q  <= rd_sel;
            end
         end

         for (genvar w = 0; w < WORDS; w++) begin : g_word
            assign word_view[w] = line_q[w*WORD_W +: WORD_W];
         end

         assign rd_word = word_view[sel_q];
      end else begin : g_early
         // Word chosen before the register: narrower output flops
         logic [WORD_W-1:0] word_q;

         always_ff @(posedge clk) begin
            if (rd_en)
               word_q <= line_mem[rd_idx][rd_sel*WORD_W +: WORD_W];
         end

         assign rd_word = word_q;
      end
   endgenerate

endmodule

// File: rtl/vipt_resolve.sv
module vipt_resolve
   import vipt_pkg::*;
#(
   parameter int TAG_W  = 19,
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   output logic              accept,
   input  logic              xlt_valid,
   input  logic [TAG_W-1:0]  xlt_ppn,
   input  logic              xlt_fault,
   input  logic              line_valid,
   input  logic [TAG_W-1:0]  line_tag,
   input  logic [WORD_W-1:0] line_word,
   output logic              rsp_hit,
   output logic              rsp_miss,
   output logic              rsp_fault,
   output logic [WORD_W-1:0] rsp_data
);

   look_st_e st_q;
   logic     tag_match;
   logic     resolve;
   res_e     res;
   logic     any_rsp;

   assign req_ready = (st_q == ST_IDLE);
   assign accept    = req_valid && req_ready;
   assign resolve   = (st_q == ST_LOOK) && xlt_valid;
   assign tag_match = line_valid && (line_tag == xlt_ppn);
   assign res       = classify(xlt_fault, tag_match);
   assign any_rsp   = rsp_hit || rsp_miss || rsp_fault;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q      <= ST_IDLE;
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_hit   <= 1'b0;
         rsp_miss  <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_data  <= '0;
         unique case (st_q)
            ST_IDLE: begin
               if (accept)
                  st_q <= ST_LOOK;
            end
            ST_LOOK: begin
               if (resolve) begin
                  st_q      <= ST_IDLE;
                  rsp_hit   <= (res == RES_HIT);
                  rsp_miss  <= (res == RES_MISS);
                  rsp_fault <= (res == RES_FAULT);
                  if (res == RES_HIT)
                     rsp_data <= line_word;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   // R10: at most one indication at a time
   p_one_indication_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rsp_hit, rsp_miss, rsp_fault}));

   // R5: a response is always preceded by translation seen while pending
   p_rsp_after_xlt_r5: assert property (@(posedge clk) disable iff (!rst_n)
      any_rsp |-> $past(xlt_valid && (st_q == ST_LOOK)));

   // R5: waiting for translation produces nothing and keeps the block busy
   p_wait_silent_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ((st_q == ST_LOOK) && !xlt_valid) |=> (!any_rsp && !req_ready));

   // R6: a fault takes precedence over the tag comparison
   p_fault_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (resolve && xlt_fault) |=> (rsp_fault && !rsp_hit && !rsp_miss));

   // R8: an accepted request blocks the next one
   p_busy_after_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);

   // R8: the block is free again when a response is shown
   p_free_on_rsp_r8: assert property (@(posedge clk) disable iff (!rst_n)
      any_rsp |-> req_ready);

   // R4, R6: data is zero unless the access hit
   p_data_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_hit |-> (rsp_data == '0));

endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup #(
   parameter int VA_W        = 32,
   parameter int PA_W        = 32,
   parameter int PAGE_OFS_W  = 13,
   parameter int SETS        = 256,
   parameter int LINE_BYTES  = 32,
   parameter int WORD_W      = 32,
   parameter bit LATE_SELECT = 1'b0
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         req_valid,
   input  logic [VA_W-1:0]              req_vaddr,
   output logic                         req_ready,
   input  logic                         xlt_valid,
   input  logic [PA_W-PAGE_OFS_W-1:0]   xlt_ppn,
   input  logic                         xlt_fault,
   input  logic                         fill_valid,
   input  logic [$clog2(SETS)-1:0]      fill_set,
   input  logic [PA_W-PAGE_OFS_W-1:0]   fill_ppn,
   input  logic [LINE_BYTES*8-1:0]      fill_line,
   output logic                         rsp_hit,
   output logic                         rsp_miss,
   output logic                         rsp_fault,
   output logic [WORD_W-1:0]            rsp_data
);

   localparam int TAG_W      = PA_W - PAGE_OFS_W;
   localparam int IDX_W      = $clog2(SETS);
   localparam int WORD_BYTES = WORD_W / 8;
   localparam int WORDS      = LINE_BYTES / WORD_BYTES;
   localparam int SEL_W      = $clog2(WORDS);
   localparam int BYTE_W     = $clog2(WORD_BYTES);
   localparam int LINE_OFS_W = $clog2(LINE_BYTES);
   localparam int SEL_LSB    = BYTE_W;
   localparam int IDX_LSB    = LINE_OFS_W;
   localparam int IDX_MSB    = IDX_LSB + IDX_W - 1;

   // Elaboration-time checks on the geometry
   generate
      if (IDX_W + LINE_OFS_W > PAGE_OFS_W) begin : g_bad_alias
         $error("index and line offset must fit inside the page offset");
      end
      if ((1 << IDX_W) != SETS) begin : g_bad_sets
         $error("SETS must be a power of two");
      end
      if ((WORD_W % 8) != 0 || (LINE_BYTES % WORD_BYTES) != 0) begin : g_bad_word
         $error("line must hold a whole number of byte-aligned words");
      end
      if (WORDS < 2) begin : g_bad_words
         $error("a line must hold at least two words");
      end
      if (VA_W <= PAGE_OFS_W || PA_W <= PAGE_OFS_W) begin : g_bad_addr
         $error("addresses must be wider than the page offset");
      end
   endgenerate

   logic [IDX_W-1:0]  look_idx;
   logic [SEL_W-1:0]  look_sel;
   logic              accept;
   logic              line_valid;
   logic [TAG_W-1:0]  line_tag;
   logic [WORD_W-1:0] line_word;
   logic              vaddr_unused;

   // Only page-offset bits reach the arrays: no aliasing across pages
   assign look_idx     = req_vaddr[IDX_MSB:IDX_LSB];
   assign look_sel     = req_vaddr[SEL_LSB +: SEL_W];
   assign vaddr_unused = ^{req_vaddr[VA_W-1:IDX_MSB+1], req_vaddr[SEL_LSB-1:0]};

   vipt_tag_store #(
      .SETS  (SETS),
      .TAG_W (TAG_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (accept),
      .rd_idx   (look_idx),
      .wr_en    (fill_valid),
      .wr_idx   (fill_set),
      .wr_tag   (fill_ppn),
      .rd_valid (line_valid),
      .rd_tag   (line_tag)
   );

   vipt_data_store #(
      .SETS        (SETS),
      .WORDS       (WORDS),
      .WORD_W      (WORD_W),
      .LATE_SELECT (LATE_SELECT)
   ) u_data (
      .clk     (clk),
      .rd_en   (accept),
      .rd_idx  (look_idx),
      .rd_sel  (look_sel),
      .wr_en   (fill_valid),
      .wr_idx  (fill_set),
      .wr_line (fill_line),
      .rd_word (line_word)
   );

   vipt_resolve #(
      .TAG_W  (TAG_W),
      .WORD_W (WORD_W)
   ) u_resolve (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_valid  (req_valid),
      .req_ready  (req_ready),
      .accept     (accept),
      .xlt_valid  (xlt_valid),
      .xlt_ppn    (xlt_ppn),
      .xlt_fault  (xlt_fault),
      .line_valid (line_valid),
      .line_tag   (line_tag),
      .line_word  (line_word),
      .rsp_hit    (rsp_hit),
      .rsp_miss   (rsp_miss),
      .rsp_fault  (rsp_fault),
      .rsp_data   (rsp_data)
   );

   // R3: a hit is only possible for a line that was valid at acceptance
   p_hit_needs_line_r3: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_hit |-> $past(line_valid));

   // R1: the block comes out of reset able to take a request
   p_ready_in_reset_r1: assert property (@(posedge clk)
      !rst_n |-> (req_ready && !rsp_hit && !rsp_miss && !rsp_fault));

endmodule

// File: tb/vipt_lookup_bench.sv
module vipt_lookup_bench;

   localparam int CLK_P = 10;
   localparam int K_HIT = 0, K_MISS = 1, K_FAULT = 2;

   // {vaddr[31:0], ppn[18:0], fault, wait[2:0], expect[1:0]}
   localparam logic [56:0] TBL [9] = '{
      {{19'h11111, 8'd3,   3'd5, 2'd0}, 19'h12345, 1'b0, 3'd0, 2'd0},
      {{19'h00007, 8'd3,   3'd0, 2'd0}, 19'h12345, 1'b0, 3'd1, 2'd0},
      {{19'h11111, 8'd3,   3'd1, 2'd0}, 19'h12346, 1'b0, 3'd0, 2'd1},
      {{19'h2AAAA, 8'd200, 3'd7, 2'd0}, 19'h00ABC, 1'b0, 3'd3, 2'd0},
      {{19'h7FFFF, 8'd255, 3'd0, 2'd0}, 19'h7FFFF, 1'b0, 3'd0, 2'd0},
      {{19'h00010, 8'd4,   3'd2, 2'd0}, 19'h00004, 1'b0, 3'd2, 2'd1},
      {{19'h2AAAA, 8'd200, 3'd1, 2'd0}, 19'h00ABC, 1'b1, 3'd1, 2'd2},
      {{19'h00001, 8'd0,   3'd2, 2'd0}, 19'h00001, 1'b0, 3'd0, 2'd0},
      {{19'h00010, 8'd4,   3'd3, 2'd0}, 19'h00004, 1'b1, 3'd0, 2'd2}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         req_valid = 1'b0;
   logic [31:0]  req_vaddr = '0;
   logic         req_ready;
   logic         xlt_valid = 1'b0;
   logic [18:0]  xlt_ppn = '0;
   logic         xlt_fault = 1'b0;
   logic         fill_valid = 1'b0;
   logic [7:0]   fill_set = '0;
   logic [18:0]  fill_ppn = '0;
   logic [255:0] fill_line = '0;
   logic         rsp_hit, rsp_miss, rsp_fault;
   logic [31:0]  rsp_data;

   int checks = 0;
   int errors = 0;

   always #(CLK_P/2) clk = ~clk;

   vipt_lookup u_vipt_lookup (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_vaddr(req_vaddr), .req_ready(req_ready),
      .xlt_valid(xlt_valid), .xlt_ppn(xlt_ppn), .xlt_fault(xlt_fault),
      .fill_valid(fill_valid), .fill_set(fill_set), .fill_ppn(fill_ppn),
      .fill_line(fill_line),
      .rsp_hit(rsp_hit), .rsp_miss(rsp_miss), .rsp_fault(rsp_fault),
      .rsp_data(rsp_data)
   );

   function automatic logic [31:0] wd(input int s, input int w, input logic [18:0] p);
      return {p[15:0], 8'(s), 8'(w)};
   endfunction

   function automatic logic [255:0] mk_line(input int s, input logic [18:0] p);
      logic [255:0] l;
      for (int w = 0; w < 8; w++) l[w*32 +: 32] = wd(s, w, p);
      return l;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [2:0] rsp_vec();
      return {rsp_hit, rsp_miss, rsp_fault};
   endfunction

   function automatic logic [2:0] kind_vec(input int k);
      return (k == K_HIT) ? 3'b100 : (k == K_MISS) ? 3'b010 : 3'b001;
   endfunction

   task automatic do_fill(input int s, input logic [18:0] p, input logic [255:0] l);
      @(negedge clk);
      fill_valid = 1'b1; fill_set = 8'(s); fill_ppn = p; fill_line = l;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // Accept a request, wait, supply translation, check the one-cycle response
   task automatic lookup(input logic [31:0] va, input logic [18:0] p, input logic f,
                         input int waitc, input int kind, input logic [31:0] exp_d,
                         input string req);
      @(negedge clk);
      chk(req_ready, "R8", "ready before request", 64'(req_ready), 64'd1);
      req_valid = 1'b1; req_vaddr = va;
      @(negedge clk);
      req_valid = 1'b0;
      chk(!req_ready, "R8", "busy after accept", 64'(req_ready), 64'd0);
      for (int i = 0; i < waitc; i++) begin
         @(negedge clk);
         chk(rsp_vec() == 3'b000, "R5", "silent while waiting", 64'(rsp_vec()), 64'd0);
      end
      xlt_valid = 1'b1; xlt_ppn = p; xlt_fault = f;
      @(negedge clk);
      xlt_valid = 1'b0; xlt_fault = 1'b0;
      chk(rsp_vec() == kind_vec(kind), req, "indication", 64'(rsp_vec()), 64'(kind_vec(kind)));
      chk(rsp_data == exp_d, req, "data", 64'(rsp_data), 64'(exp_d));
      @(negedge clk);
      chk(rsp_vec() == 3'b000, "R10", "single-cycle pulse", 64'(rsp_vec()), 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
      chk(rsp_vec() == 3'b000, "R1", "no response in reset", 64'(rsp_vec()), 64'd0);
      rst_n = 1'b1;
      lookup({19'h11111, 8'd3, 3'd5, 2'd0}, 19'h12345, 1'b0, 0, K_MISS, 32'd0, "R1");

      // R5: translation while idle is ignored
      @(negedge clk);
      xlt_valid = 1'b1; xlt_ppn = 19'h12345;
      @(negedge clk);
      xlt_valid = 1'b0;
      chk(rsp_vec() == 3'b000, "R5", "idle translation ignored", 64'(rsp_vec()), 64'd0);

      // R7: fills
      do_fill(3,   19'h12345, mk_line(3,   19'h12345));
      do_fill(200, 19'h00ABC, mk_line(200, 19'h00ABC));
      do_fill(255, 19'h7FFFF, mk_line(255, 19'h7FFFF));
      do_fill(0,   19'h00001, mk_line(0,   19'h00001));

      // Vector table: R2, R3, R4, R5, R6, R7
      for (int i = 0; i < 9; i++) begin
         logic [31:0] va;
         logic [18:0] p;
         int k;
         logic [31:0] ed;
         va = TBL[i][56:25];
         p  = TBL[i][24:6];
         k  = int'(TBL[i][1:0]);
         ed = (k == K_HIT) ? wd(int'(va[12:5]), int'(va[4:2]), p) : 32'd0;
         lookup(va, p, TBL[i][5], int'(TBL[i][4:2]), k, ed,
                (k == K_HIT) ? "R3" : (k == K_MISS) ? "R4" : "R6");
      end

      // R8: request while busy is ignored
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {19'h00001, 8'd0, 3'd2, 2'd0};
      @(negedge clk);
      req_vaddr = {19'h00010, 8'd4, 3'd1, 2'd0};
      @(negedge clk);
      req_valid = 1'b0;
      xlt_valid = 1'b1; xlt_ppn = 19'h00001;
      @(negedge clk);
      xlt_valid = 1'b0;
      chk(rsp_hit && rsp_data == wd(0, 2, 19'h00001), "R8", "first request answered",
          64'(rsp_data), 64'(wd(0, 2, 19'h00001)));
      @(negedge clk);
      xlt_valid = 1'b1; xlt_ppn = 19'h00004;
      @(negedge clk);
      xlt_valid = 1'b0;
      chk(rsp_vec() == 3'b000 && req_ready, "R8", "busy request not started",
          64'(rsp_vec()), 64'd0);

      // R9: fill and request to the same set in the same cycle
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {19'h00333, 8'd10, 3'd1, 2'd0};
      fill_valid = 1'b1; fill_set = 8'd10; fill_ppn = 19'h0AAAA;
      fill_line = mk_line(10, 19'h0AAAA);
      @(negedge clk);
      req_valid = 1'b0; fill_valid = 1'b0;
      xlt_valid = 1'b1; xlt_ppn = 19'h0AAAA;
      @(negedge clk);
      xlt_valid = 1'b0;
      chk(rsp_vec() == 3'b010, "R9", "same-cycle fill not seen", 64'(rsp_vec()), 64'h2);
      lookup({19'h00333, 8'd10, 3'd1, 2'd0}, 19'h0AAAA, 1'b0, 0, K_HIT,
             wd(10, 1, 19'h0AAAA), "R9");

      // R9: fill while a lookup of the same set waits for translation
      @(negedge clk);
      req_valid = 1'b1; req_vaddr = {19'h00044, 8'd200, 3'd3, 2'd0};
      @(negedge clk);
      req_valid = 1'b0;
      fill_valid = 1'b1; fill_set = 8'd200; fill_ppn = 19'h00DEF;
      fill_line = mk_line(200, 19'h00DEF);
      xlt_valid = 1'b1; xlt_ppn = 19'h00ABC;
      @(negedge clk);
      fill_valid = 1'b0; xlt_valid = 1'b0;
      chk(rsp_hit && rsp_data == wd(200, 3, 19'h00ABC), "R9", "pending lookup keeps old line",
          64'(rsp_data), 64'(wd(200, 3, 19'h00ABC)));
      lookup({19'h00044, 8'd200, 3'd3, 2'd0}, 19'h00ABC, 1'b0, 0, K_MISS, 32'd0, "R9");
      lookup({19'h00044, 8'd200, 3'd6, 2'd0}, 19'h00DEF, 1'b0, 1, K_HIT,
             wd(200, 6, 19'h00DEF), "R7");

      // R1: reset in mid-run clears the valid bits
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk(req_ready && rsp_vec() == 3'b000, "R1", "state after mid-run reset",
          64'(rsp_vec()), 64'd0);
      rst_n = 1'b1;
      lookup({19'h11111, 8'd3, 3'd5, 2'd0}, 19'h12345, 1'b0, 0, K_MISS, 32'd0, "R1");

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule